// File: doc/BRIEF.md
# Slot-Table Bus Arbiter with Round-Robin Fallback

This arbiter decides which of several initiators may use a shared on-chip interconnect. It steps through a programmable table of time slots. Each entry either names one initiator as the slot's owner or leaves the slot unowned. When the owner of the current slot is requesting, the owner wins. When the owner is not requesting, or the slot has no owner, the slot is not lost: it goes to a round-robin choice among the initiators that are requesting. Requests are assumed to be synchronous to the arbiter's clock already.

After a decision, the one-hot grant is held for a programmable number of cycles (2 to 7). A one-cycle start strobe marks the last of those cycles, when the data phase of the winning initiator begins. The grant then drops for one cycle, and the next decision follows. The slot table and the latency can only be written while arbitration is switched off.

Top module: `slot_arbiter`

## Requirements
- R1: After reset, `gnt` is 0, `data_start` is 0 and `cur_slot` is 0. Every table entry is unowned, the round-robin pointer is 0 and the latency is 2.
- R2: If the current slot's entry is valid and its owner ID (bit i of `gnt` stands for initiator i) is requesting, the next grant goes to that owner.
- R3: If the current slot is unowned, or its owner is not requesting, the grant goes to the first requesting initiator found by searching upward, with wrap-around, from the round-robin pointer.
- R4: A grant made by the round-robin path sets the pointer to one past the initiator granted, modulo the number of initiators. A grant made to the owner leaves the pointer unchanged.
- R5: `gnt` is one-hot or zero, and it stays constant from the cycle it rises until the cycle that carries `data_start`. `data_start` never lasts more than one cycle.
- R6: With a programmed latency L, `gnt` is high for exactly L cycles, and `data_start` is high in the last of them.
- R7: A latency write of 0 or 1 stores 2. A write of 8 to 15 (4-bit field) stores 7. Values 2 to 7 are stored unchanged.
- R8: `cur_slot` advances by one at the end of each grant, and on each enabled idle cycle with no request at all. It wraps from 15 to 0.
- R9: No grant is issued while no initiator is requesting, or while `arb_en` is low.
- R10: Writes to the table and to the latency are ignored while `arb_en` is high.
- R11: After `data_start`, `gnt` is 0 for exactly one cycle. If requests persist, a new grant appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Arbiter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_en | input | 1 | Enables arbitration; configuration writes are blocked while high |
| cfg_we | input | 1 | Slot table write strobe |
| cfg_addr | input | 4 | Slot table entry to write |
| cfg_valid | input | 1 | Entry has an owner |
| cfg_owner | input | 2 | Owning initiator ID |
| lat_we | input | 1 | Latency write strobe |
| lat_val | input | 4 | Requested latency, clamped to 2..7 |
| req | input | 4 | Request per initiator |
| gnt | output | 4 | One-hot grant |
| data_start | output | 1 | One-cycle data-phase start strobe |
| cur_slot | output | 4 | Current slot table index |

## Verification
On every cycle, the assertions check that the grant is one-hot, that it stays fixed until the strobe, that the strobe lasts one cycle, that the idle gap follows the strobe, that every new grant goes to an initiator that was requesting, that no grant follows an idle cycle without requests, and that the stored latency stays in range. Only the bench's scenarios can show which initiator should win: owner against fallback, the movement of the round-robin pointer, the exact grant length for each programmed latency, clamping, blocked writes, and slot wrap-around. All of these depend on a history of configuration and grants that a single-cycle property does not carry.

// File: rtl/slot_arbiter.sv
module slot_arbiter #(
  parameter int N_INIT = 4,
  parameter int SLOTS  = 16,
  localparam int IDW = $clog2(N_INIT),
  localparam int SW  = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arb_en,
  input  logic              cfg_we,
  input  logic [SW-1:0]     cfg_addr,
  input  logic              cfg_valid,
  input  logic [IDW-1:0]    cfg_owner,
  input  logic              lat_we,
  input  logic [3:0]        lat_val,
  input  logic [N_INIT-1:0] req,
  output logic [N_INIT-1:0] gnt,
  output logic              data_start,
  output logic [SW-1:0]     cur_slot
);

  logic [SLOTS-1:0] tv;
  logic [IDW-1:0]   town [SLOTS];
  logic [IDW-1:0]   rr, rr_sel, pick;
  logic [2:0]       lat, cnt;
  logic             busy, own_hit;

  assign own_hit    = tv[cur_slot] && req[town[cur_slot]];
  assign pick       = own_hit ? town[cur_slot] : rr_sel;
  assign data_start = busy && (cnt == 3'd1);

  always_comb begin
    rr_sel = rr;
    for (int k = N_INIT - 1; k >= 0; k--) begin
      if (req[rr + IDW'(k)]) rr_sel = rr + IDW'(k);
    end
  end

  always_ff @(posedge clk) begin
    if (cfg_we && !arb_en) town[cfg_addr] <= cfg_owner;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tv       <= '0;
      lat      <= 3'd2;
      busy     <= 1'b0;
      cnt      <= '0;
      gnt      <= '0;
      rr       <= '0;
      cur_slot <= '0;
    end else begin
      if (cfg_we && !arb_en) tv[cfg_addr] <= cfg_valid;
      if (lat_we && !arb_en)
        lat <= (lat_val < 4'd2) ? 3'd2 : (lat_val > 4'd7) ? 3'd7 : lat_val[2:0];
      if (busy) begin
        cnt <= cnt - 3'd1;
        if (cnt == 3'd1) begin
          busy     <= 1'b0;
          gnt      <= '0;
          cur_slot <= cur_slot + 1'b1;
        end
      end else if (arb_en) begin
        if (req == '0) begin
          cur_slot <= cur_slot + 1'b1;
        end else begin
          busy <= 1'b1;
          cnt  <= lat;
          gnt  <= N_INIT'(1) << pick;
          if (!own_hit) rr <= rr_sel + 1'b1;
        end
      end
    end
  end

  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt != '0 && !data_start) |=> $stable(gnt));
  p_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |=> !data_start);
  p_strobe_in_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |-> gnt != '0);
  p_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
    data_start |=> gnt == '0);
  p_winner_requested_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|gnt) |-> (gnt & $past(req)) != '0);
  p_no_req_no_grant_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (req == '0 || !arb_en)) |=> gnt == '0);
  p_lat_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    lat >= 3'd2 && lat <= 3'd7);

endmodule

// File: tb/slot_arbiter_test.sv
module slot_arbiter_test;
  logic       clk = 0, rst_n = 0, arb_en = 0, cfg_we = 0, cfg_valid = 0, lat_we = 0;
  logic [3:0] cfg_addr = 0, lat_val = 0, req = 0;
  logic [1:0] cfg_owner = 0;
  logic [3:0] gnt, cur_slot;
  logic       data_start;
  int         n_chk = 0, n_bad = 0;

  slot_arbiter uut (.clk, .rst_n, .arb_en, .cfg_we, .cfg_addr, .cfg_valid, .cfg_owner,
                    .lat_we, .lat_val, .req, .gnt, .data_start, .cur_slot);

  always #4 clk = ~clk;

  task automatic step; @(negedge clk); endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic set_entry(input int s, input bit v, input int o);
    cfg_we = 1; cfg_addr = 4'(s); cfg_valid = v; cfg_owner = 2'(o);
    step; cfg_we = 0;
  endtask

  task automatic set_lat(input int l);
    lat_we = 1; lat_val = 4'(l); step; lat_we = 0;
  endtask

  task automatic run_grant(input logic [3:0] rq, input logic [3:0] eg, input int el, input string tag);
    logic [3:0] g0, s0;
    int n;
    s0 = cur_slot; req = rq; arb_en = 1; step;
    check(gnt == eg, tag, gnt, eg);
    g0 = gnt; n = 1;
    while (!data_start && n < 20) begin
      step; n++;
      check(gnt == g0, "R5 grant held", gnt, g0);
    end
    check(n == el, "R6 grant length", n, el);
    step;
    check(gnt == 0 && !data_start, "R11 gap after strobe", gnt, 0);
    check(cur_slot == s0 + 4'd1, "R8 slot advance", cur_slot, s0 + 4'd1);
    req = 0; arb_en = 0; cfg_we = 0; lat_we = 0;
  endtask

  task automatic t_reset;
    check(gnt == 0 && !data_start, "R1 reset grant", gnt, 0);
    check(cur_slot == 0, "R1 reset slot", cur_slot, 0);
  endtask

  task automatic t_select;
    set_entry(0, 1, 2); set_entry(1, 1, 3); set_entry(3, 1, 0);
    set_lat(0);
    run_grant(4'b1111, 4'b0100, 2, "R2 owner wins, R7 low clamp");
    run_grant(4'b0011, 4'b0001, 2, "R3 owner idle, fallback");
    run_grant(4'b0011, 4'b0010, 2, "R4 pointer moved");
    run_grant(4'b1001, 4'b0001, 2, "R2 owner grant");
    run_grant(4'b1011, 4'b1000, 2, "R4 owner grant left pointer");
  endtask

  task automatic t_idle;
    req = 4'b0110; step;
    check(gnt == 0, "R9 disabled no grant", gnt, 0);
    req = 0; arb_en = 1;
    for (int i = 0; i < 3; i++) begin
      step;
      check(gnt == 0, "R9 no request", gnt, 0);
    end
    check(cur_slot == 8, "R8 idle advance", cur_slot, 8);
    arb_en = 0;
  endtask

  task automatic t_latency_and_lock;
    set_lat(13);
    cfg_we = 1; cfg_addr = 9; cfg_valid = 1; cfg_owner = 2;
    lat_we = 1; lat_val = 3;
    run_grant(4'b0100, 4'b0100, 7, "R7 high clamp, R3 unowned");
    run_grant(4'b0101, 4'b0001, 7, "R10 writes blocked while enabled");
  endtask

  task automatic t_wrap;
    arb_en = 1; req = 0;
    for (int i = 0; i < 5; i++) step;
    check(cur_slot == 15, "R8 last slot", cur_slot, 15);
    step;
    check(cur_slot == 0, "R8 wrap", cur_slot, 0);
    arb_en = 0;
  endtask

  task automatic t_back_to_back;
    set_lat(3);
    req = 4'b0100; arb_en = 1; step;
    check(gnt == 4'b0100, "R2 first of pair", gnt, 4'b0100);
    step; step;
    check(data_start == 1, "R6 strobe at third cycle", data_start, 1);
    step;
    check(gnt == 0, "R11 one-cycle gap", gnt, 0);
    step;
    check(gnt == 4'b0100, "R11 next grant follows gap", gnt, 4'b0100);
    arb_en = 0;
    for (int i = 0; i < 4; i++) step;
    check(gnt == 0, "R9 disabled after pair", gnt, 0);
    check(cur_slot == 2, "R8 two grants", cur_slot, 2);
    req = 0;
  endtask

  initial begin
    step; step; rst_n = 1; step;
    t_reset;
    t_select;
    t_idle;
    t_latency_and_lock;
    t_wrap;
    t_back_to_back;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule